// File: doc/BRIEF.md
# Indirect Configuration Access Translator

This block turns host I/O accesses into configuration requests. Software first writes a 32-bit address word to an address port at I/O CF8h. That word holds an enable bit, a bus number, a device number, a function number and a dword register number. Software then reads or writes the 32-bit data window at I/O CFCh–CFFh. When the enable bit is set, each window access becomes one configuration request on a valid/ready channel. The request carries the decoded target fields, the byte enables, the write data, a cycle type and the address-phase word. It also carries a routing flag that sends it either to the chipset's own registers or to a downstream PCI bus.

Routing uses two inputs. The first is the chipset's own bus number, held in a register outside this block. The second is the number of the directly attached secondary bus. Bus 0 device 16 is always claimed internally, so the chipset bus number can be programmed before it is known. Reads wait for a response. A forwarded read that gets no response within a fixed number of cycles completes with all ones.

The host side uses a level request `io_valid`, which is held until a one-cycle `io_done` pulse. The host drops `io_valid` in the cycle after `io_done`.

Top module: `cfg_xlate`

## Requirements
- R1: After reset the address word is 00000000h, `cfg_valid` and `io_done` are low, and a read of CF8h returns 00000000h.
- R2: A write to CF8h with all four byte enables set (4'b1111) loads the address word. A write with any other byte enable pattern leaves the address word unchanged. A read of CF8h returns the address word with bits 1:0 forced to 0.
- R3: When address bit 31 is 0, an access to CFCh–CFFh issues no configuration request, completes with `io_done` one cycle after acceptance, and a read returns 00000000h.
- R4: When address bit 31 is 1, an access to CFCh–CFFh issues one request. In that request `cfg_bus`=addr[23:16], `cfg_dev`=addr[15:11], `cfg_func`=addr[10:8] and `cfg_reg`=addr[7:2]. `cfg_be`, `cfg_wdata` and `cfg_write` are the host's values unchanged, and the sub-dword addresses CFDh–CFFh also count as window hits.
- R5: A request to bus 0, device 16 has `cfg_internal`=1, whatever the chipset bus number is.
- R6: A request whose bus equals `chip_bus` has `cfg_internal`=1 for every device number 0–31. Any request that matches neither this rule nor R5 has `cfg_internal`=0.
- R7: An internal request, or a forwarded request whose bus equals `sec_bus`, is type 0 (`cfg_type1`=0). Its `cfg_ad` is {16'h0, dev, func, reg, 2'b00}.
- R8: A forwarded request to any other bus is type 1 (`cfg_type1`=1). Its `cfg_ad` is {8'h00, bus, dev, func, reg, 2'b01}.
- R9: A write completes (`io_done`) one cycle after the request is accepted. A read completes one cycle after `rsp_valid` and returns `rsp_data`.
- R10: A forwarded read with no `rsp_valid` completes with FFFFFFFFh exactly TMO_CYCLES cycles after acceptance. An internal read waits for its response with no time limit.
- R11: An access to any other I/O address issues no request, completes one cycle after acceptance, returns FFFFFFFFh on a read and leaves the address word unchanged.
- R12: While `cfg_valid` is high and `cfg_ready` is low, the request and all of its fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_bus | input | 8 | Chipset's own bus number |
| sec_bus | input | 8 | Directly attached secondary bus number |
| io_valid | input | 1 | Host access request, held until io_done |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| io_done | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid with io_done |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Configuration request accepted |
| cfg_write | output | 1 | Request is a write |
| cfg_internal | output | 1 | 1 = chipset registers, 0 = downstream bus |
| cfg_type1 | output | 1 | 1 = type 1 cycle |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_func | output | 3 | Target function |
| cfg_reg | output | 6 | Target dword register |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cfg_ad | output | 32 | Address-phase word |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read response data |

## Verification
A corrupted address word shows up at the next window access as wrong target fields, wrong routing or a wrong `cfg_ad`. It also shows up at once on a read of CF8h. A wrong sequencer state appears within one access: as a missing or extra request, an `io_done` in the wrong cycle, or a forwarded read that ends at a cycle other than TMO_CYCLES. A routing error shows directly on `cfg_internal`/`cfg_type1` and the low bits of `cfg_ad` in the same cycle the request appears.

// File: rtl/cfg_xlate_pkg.sv
// Package: shared types for the configuration access translator.
// Assumes: one outstanding host access at a time.
package cfg_xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [5:0] regno;
    } cfg_tgt_t;

endpackage

// File: rtl/cfg_addr_reg.sv
// Module: address word storage behind the address port.
// Holds the enable/bus/device/function/register word; bits 1:0 are
// always stored as zero. Assumes the load strobe already qualifies a
// full-dword write.
module cfg_addr_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] addr_q
);

    // Load the word on strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr_q <= '0;
        else if (ld_en) addr_q <= {ld_data[DW-1:2], 2'b00};
    end

    // R2: reserved low bits never hold a one.
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> addr_q[1:0] == 2'b00);

endmodule

// File: rtl/cfg_route.sv
// Module: combinational decode of the address word.
// Splits the word into target fields, picks internal vs forwarded
// routing and the cycle type, and builds the address-phase word.
// Assumes chip_bus/sec_bus are static while a request is open.
module cfg_route
    import cfg_xlate_pkg::*;
#(
    parameter int DW       = 32,
    parameter int BUSW     = 8,
    parameter int RSVD_DEV = 16
) (
    input  logic [DW-1:0]   addr_q,
    input  logic [BUSW-1:0] chip_bus,
    input  logic [BUSW-1:0] sec_bus,
    output cfg_tgt_t        tgt,
    output logic            cfg_en,
    output logic            internal,
    output logic            type1,
    output logic [DW-1:0]   ad
);

    logic unused_bits;
    logic boot_hit;
    logic own_hit;

    // Field extraction from the stored word.
    always_comb begin
        cfg_en    = addr_q[31];
        tgt.bus   = addr_q[23:16];
        tgt.dev   = addr_q[15:11];
        tgt.func  = addr_q[10:8];
        tgt.regno = addr_q[7:2];
    end

    assign unused_bits = ^{addr_q[30:24], addr_q[1:0]};

    // Routing decision and cycle type.
    always_comb begin
        boot_hit = (tgt.bus == '0) && (tgt.dev == 5'(RSVD_DEV));
        own_hit  = (tgt.bus == chip_bus);
        internal = boot_hit || own_hit;
        type1    = !internal && (tgt.bus != sec_bus);
    end

    // Address-phase word per cycle type.
    always_comb begin
        if (type1) ad = {8'h00, tgt.bus, tgt.dev, tgt.func, tgt.regno, 2'b01};
        else       ad = {16'h0000, tgt.dev, tgt.func, tgt.regno, 2'b00};
    end

endmodule

// File: rtl/cfg_seq.sv
// Module: access sequencer.
// Accepts one host access, classifies it (address port, enabled window,
// disabled window, miss), issues the configuration request, waits for
// the read response or a timeout, and pulses io_done once.
// Assumes the host drops io_valid in the cycle after io_done.
module cfg_seq
    import cfg_xlate_pkg::*;
#(
    parameter int DW         = 32,
    parameter int BEW        = DW / 8,
    parameter int TMO_CYCLES = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           io_valid,
    input  logic           io_write,
    input  logic [BEW-1:0] io_be,
    input  logic [DW-1:0]  io_wdata,
    input  logic           hit_addr,
    input  logic           hit_data,
    input  logic           cfg_en,
    input  logic           internal,
    input  logic [DW-1:0]  addr_q,
    output logic           addr_ld,
    output logic           io_done,
    output logic [DW-1:0]  io_rdata,
    output logic           cfg_valid,
    input  logic           cfg_ready,
    output logic           cfg_write,
    output logic [BEW-1:0] cfg_be,
    output logic [DW-1:0]  cfg_wdata,
    input  logic           rsp_valid,
    input  logic [DW-1:0]  rsp_data
);

    localparam int TW = $clog2(TMO_CYCLES + 1);

    seq_state_t    state;
    logic [TW-1:0] timer;

    // Address port load strobe: full-dword writes only.
    assign addr_ld = (state == ST_IDLE) && io_valid && hit_addr && io_write
                     && (io_be == {BEW{1'b1}});

    assign cfg_valid = (state == ST_REQ);
    assign io_done   = (state == ST_DONE);

    // Main sequencer, request capture, timer and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            timer     <= '0;
            io_rdata  <= '0;
            cfg_write <= 1'b0;
            cfg_be    <= '0;
            cfg_wdata <= '0;
        end else begin
            case (state)
                ST_IDLE: if (io_valid) begin
                    if (hit_addr) begin
                        io_rdata <= io_write ? '0 : addr_q;
                        state    <= ST_DONE;
                    end else if (hit_data && cfg_en) begin
                        cfg_write <= io_write;
                        cfg_be    <= io_be;
                        cfg_wdata <= io_wdata;
                        state     <= ST_REQ;
                    end else if (hit_data) begin
                        io_rdata <= '0;
                        state    <= ST_DONE;
                    end else begin
                        io_rdata <= '1;
                        state    <= ST_DONE;
                    end
                end
                ST_REQ: if (cfg_ready) begin
                    timer <= '0;
                    if (cfg_write) begin
                        io_rdata <= '0;
                        state    <= ST_DONE;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        io_rdata <= rsp_data;
                        state    <= ST_DONE;
                    end else if (!internal && timer == TW'(TMO_CYCLES - 1)) begin
                        io_rdata <= '1;
                        state    <= ST_DONE;
                    end else if (!internal) begin
                        timer <= timer + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R12: a stalled request keeps its payload.
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_wdata)
                                       && $stable(cfg_be) && $stable(cfg_write)));

    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_done |=> !io_done);

    // R10: the timeout counter never passes its limit.
    p_tmo_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timer < TW'(TMO_CYCLES));

    // R9: an accepted write finishes on the next cycle.
    p_wr_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_ready && cfg_write) |=> io_done);

endmodule

// File: rtl/cfg_xlate.sv
// Module: top of the indirect configuration access translator.
// Decodes host I/O addresses to the address port and data window, then
// ties together the address word, the routing decode and the sequencer.
// Assumes a single host master with one access in flight.
module cfg_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int          IO_AW      = 16,
    parameter int          DW         = 32,
    parameter int          BEW        = DW / 8,
    parameter int          BUSW       = 8,
    parameter logic [15:0] ADDR_PORT  = 16'h0CF8,
    parameter logic [15:0] DATA_PORT  = 16'h0CFC,
    parameter int          TMO_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUSW-1:0]  chip_bus,
    input  logic [BUSW-1:0]  sec_bus,
    input  logic             io_valid,
    input  logic             io_write,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [BEW-1:0]   io_be,
    input  logic [DW-1:0]    io_wdata,
    output logic             io_done,
    output logic [DW-1:0]    io_rdata,
    output logic             cfg_valid,
    input  logic             cfg_ready,
    output logic             cfg_write,
    output logic             cfg_internal,
    output logic             cfg_type1,
    output logic [7:0]       cfg_bus,
    output logic [4:0]       cfg_dev,
    output logic [2:0]       cfg_func,
    output logic [5:0]       cfg_reg,
    output logic [BEW-1:0]   cfg_be,
    output logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_ad,
    input  logic             rsp_valid,
    input  logic [DW-1:0]    rsp_data
);

    logic          hit_addr;
    logic          hit_data;
    logic          addr_ld;
    logic          cfg_en;
    logic [DW-1:0] addr_q;
    cfg_tgt_t      tgt;

    // Port decode: the address port is dword-aligned only; the window
    // accepts any byte offset inside its dword.
    always_comb begin
        hit_addr = (io_addr == ADDR_PORT[IO_AW-1:0]);
        hit_data = (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);
    end

    cfg_addr_reg #(.DW(DW)) u_areg (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (addr_ld),
        .ld_data (io_wdata),
        .addr_q  (addr_q)
    );

    cfg_route #(.DW(DW), .BUSW(BUSW)) u_route (
        .addr_q   (addr_q),
        .chip_bus (chip_bus),
        .sec_bus  (sec_bus),
        .tgt      (tgt),
        .cfg_en   (cfg_en),
        .internal (cfg_internal),
        .type1    (cfg_type1),
        .ad       (cfg_ad)
    );

    cfg_seq #(.DW(DW), .BEW(BEW), .TMO_CYCLES(TMO_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_valid  (io_valid),
        .io_write  (io_write),
        .io_be     (io_be),
        .io_wdata  (io_wdata),
        .hit_addr  (hit_addr),
        .hit_data  (hit_data),
        .cfg_en    (cfg_en),
        .internal  (cfg_internal),
        .addr_q    (addr_q),
        .addr_ld   (addr_ld),
        .io_done   (io_done),
        .io_rdata  (io_rdata),
        .cfg_valid (cfg_valid),
        .cfg_ready (cfg_ready),
        .cfg_write (cfg_write),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // Field fan-out to the request channel.
    always_comb begin
        cfg_bus  = tgt.bus;
        cfg_dev  = tgt.dev;
        cfg_func = tgt.func;
        cfg_reg  = tgt.regno;
    end

    // R5: bus 0 device 16 is always claimed.
    p_boot_dev_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_bus == 8'h00 && cfg_dev == 5'd16) |-> cfg_internal);

    // R6: the chipset's own bus is always claimed.
    p_own_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_bus == chip_bus) |-> (cfg_internal && !cfg_type1));

    // R8: type 1 address phase carries the bus and the 01 marker.
    p_type1_ad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_type1) |-> (cfg_ad[1:0] == 2'b01
                                      && cfg_ad[23:16] == cfg_bus));

    // R3: no request can start while the enable bit is clear.
    p_no_req_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid) |-> addr_q[31]);

    // R12: target fields hold while a request is stalled.
    p_tgt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |=> ($stable(cfg_ad) && $stable(cfg_internal)));

endmodule

// File: tb/cfg_xlate_tb.sv
// Bench for cfg_xlate: directed corner cases plus seeded random accesses,
// each checked against values computed from the requirements.
module cfg_xlate_tb;

    localparam int          TMO   = 16;
    localparam logic [7:0]  CHIP  = 8'h40;
    localparam logic [7:0]  SEC   = 8'h01;
    localparam logic [15:0] A_PRT = 16'h0CF8;
    localparam logic [15:0] D_PRT = 16'h0CFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0, io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        io_done;
    logic [31:0] io_rdata;
    logic        cfg_valid, cfg_ready = 1'b0, cfg_write, cfg_internal, cfg_type1;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata, cfg_ad;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;

    int checks = 0;
    int fails  = 0;

    // captured request and access result
    bit          s_req, s_stable;
    logic        s_write, s_int, s_t1;
    logic [7:0]  s_bus;
    logic [4:0]  s_dev;
    logic [2:0]  s_func;
    logic [5:0]  s_reg;
    logic [3:0]  s_be;
    logic [31:0] s_wdata, s_ad, s_rd;
    int          s_lat;

    always #10 clk = ~clk;

    cfg_xlate #(.TMO_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_bus(CHIP), .sec_bus(SEC),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_be(io_be), .io_wdata(io_wdata), .io_done(io_done),
        .io_rdata(io_rdata), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
        .cfg_write(cfg_write), .cfg_internal(cfg_internal),
        .cfg_type1(cfg_type1), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
        .cfg_func(cfg_func), .cfg_reg(cfg_reg), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_ad(cfg_ad), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    function automatic bit exp_int(input logic [7:0] b, input logic [4:0] d);
        return (b == 8'h00 && d == 5'd16) || (b == CHIP);
    endfunction

    function automatic bit exp_t1(input logic [7:0] b, input logic [4:0] d);
        return !exp_int(b, d) && (b != SEC);
    endfunction

    function automatic logic [31:0] exp_ad(input logic [7:0] b, input logic [4:0] d,
                                           input logic [2:0] f, input logic [5:0] r);
        if (exp_t1(b, d)) return {8'h00, b, d, f, r, 2'b01};
        return {16'h0000, d, f, r, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One host access; rsp_mode 0 = respond after rsp_dly cycles, 1 = never.
    task automatic xfer(input bit wr, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input int rsp_mode,
                        input int rsp_dly, input logic [31:0] rd_val);
        bit fin = 0;
        int n = 0;
        s_req = 0; s_stable = 1; s_rd = 'x; s_lat = 0;
        @(negedge clk);
        io_valid = 1; io_write = wr; io_addr = a; io_be = be; io_wdata = wd;
        while (!fin) begin
            @(negedge clk);
            n++;
            if (cfg_valid && !s_req && !io_done) begin
                s_req = 1;
                s_write = cfg_write; s_int = cfg_internal; s_t1 = cfg_type1;
                s_bus = cfg_bus; s_dev = cfg_dev; s_func = cfg_func; s_reg = cfg_reg;
                s_be = cfg_be; s_wdata = cfg_wdata; s_ad = cfg_ad;
                for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
                    @(negedge clk);
                    if (!(cfg_valid && cfg_ad == s_ad && cfg_be == s_be &&
                          cfg_wdata == s_wdata && cfg_internal == s_int))
                        s_stable = 0;
                end
                cfg_ready = 1;
                @(negedge clk);
                cfg_ready = 0;
                n = 0;
                if (!wr && rsp_mode == 0) begin
                    repeat (rsp_dly) @(negedge clk);
                    rsp_valid = 1; rsp_data = rd_val;
                    @(negedge clk);
                    rsp_valid = 0;
                    n = 0;
                end
            end
            if (io_done) begin
                s_rd = io_rdata; s_lat = n; io_valid = 0; fin = 1;
            end else if (n > 200) begin
                chk(0, "R9 access hung", 32'(n), 0);
                io_valid = 0; fin = 1;
            end
        end
    endtask

    task automatic set_addr(input logic [31:0] w);
        xfer(1, A_PRT, 4'hF, w, 0, 0, 0);
    endtask

    // Full check of an enabled window access against the model.
    task automatic cfg_case(input logic [7:0] b, input logic [4:0] d,
                            input logic [2:0] f, input logic [5:0] r,
                            input bit wr, input logic [1:0] off, input logic [3:0] be,
                            input logic [31:0] wd, input logic [31:0] rdv);
        set_addr({1'b1, 7'h00, b, d, f, r, 2'b00});
        xfer(wr, D_PRT + 16'(off), be, wd, 0, $urandom_range(0, 4), rdv);
        chk(s_req, "R4 request issued", 32'(s_req), 1);
        chk(s_stable, "R12 stall stable", 32'(s_stable), 1);
        chk({s_bus, s_dev, s_func, s_reg} == {b, d, f, r}, "R4 fields",
            {10'h0, s_bus, s_dev, s_func, s_reg}, {10'h0, b, d, f, r});
        chk(s_write == wr && s_be == be && (!wr || s_wdata == wd), "R4 payload",
            {s_be, 27'h0, s_write}, {be, 27'h0, wr});
        chk(s_int == exp_int(b, d), "R5 R6 routing", 32'(s_int), 32'(exp_int(b, d)));
        chk(s_t1 == exp_t1(b, d), "R7 R8 cycle type", 32'(s_t1), 32'(exp_t1(b, d)));
        chk(s_ad == exp_ad(b, d, f, r), "R7 R8 address phase", s_ad, exp_ad(b, d, f, r));
        if (!wr) chk(s_rd == rdv, "R9 read data", s_rd, rdv);
        else     chk(s_lat == 0, "R9 write done next cycle", 32'(s_lat), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!cfg_valid && !io_done, "R1 outputs idle", {cfg_valid, io_done}, 0);
        xfer(0, A_PRT, 4'hF, 0, 0, 0, 0);
        chk(s_rd == 0, "R1 address word reset", s_rd, 0);

        // R3: window with enable clear
        xfer(0, D_PRT, 4'hF, 0, 0, 0, 0);
        chk(!s_req && s_rd == 0 && s_lat == 1, "R3 disabled read", s_rd, 0);
        set_addr(32'h0000_1234);
        xfer(1, D_PRT + 16'd2, 4'h4, 32'hAABBCCDD, 0, 0, 0);
        chk(!s_req && s_lat == 1, "R3 disabled write no request", 32'(s_req), 0);

        // R2: load, reserved bits, partial writes ignored
        set_addr(32'h8000_0803);
        xfer(0, A_PRT, 4'hF, 0, 0, 0, 0);
        chk(s_rd == 32'h8000_0800, "R2 readback low bits zero", s_rd, 32'h8000_0800);
        xfer(1, A_PRT, 4'h3, 32'h0000_1234, 0, 0, 0);
        xfer(0, A_PRT, 4'hF, 0, 0, 0, 0);
        chk(s_rd == 32'h8000_0800, "R2 partial write ignored", s_rd, 32'h8000_0800);

        // R11: other address
        xfer(0, 16'h0080, 4'hF, 0, 0, 0, 0);
        chk(!s_req && s_rd == 32'hFFFF_FFFF && s_lat == 1, "R11 miss read", s_rd, 32'hFFFF_FFFF);
        xfer(1, 16'h0CF9, 4'hF, 32'h1, 0, 0, 0);
        xfer(0, A_PRT, 4'hF, 0, 0, 0, 0);
        chk(s_rd == 32'h8000_0800, "R11 miss leaves address word", s_rd, 32'h8000_0800);

        // Directed routing corners: R5, R6, R7, R8, R4 sub-dword
        cfg_case(8'h00, 5'd16, 3'd0, 6'd1, 0, 2'd0, 4'hF, 0, 32'h1111_0000);
        cfg_case(8'h00, 5'd3, 3'd2, 6'd5, 0, 2'd0, 4'hF, 0, 32'h2222_0000);
        cfg_case(CHIP, 5'd31, 3'd7, 6'd63, 1, 2'd0, 4'hF, 32'hCAFE_0001, 0);
        cfg_case(CHIP, 5'd0, 3'd1, 6'd2, 0, 2'd3, 4'h8, 0, 32'h3333_0000);
        cfg_case(SEC, 5'd9, 3'd4, 6'd17, 0, 2'd1, 4'h2, 0, 32'h4444_0000);
        cfg_case(8'h22, 5'd16, 3'd3, 6'd40, 1, 2'd2, 4'h4, 32'h00AB_0000, 0);

        // R10: forwarded read with no response
        set_addr({1'b1, 7'h0, 8'h22, 5'd4, 3'd0, 6'd0, 2'b00});
        xfer(0, D_PRT, 4'hF, 0, 1, 0, 0);
        chk(s_rd == 32'hFFFF_FFFF, "R10 timeout data", s_rd, 32'hFFFF_FFFF);
        chk(s_lat == TMO, "R10 timeout cycle", 32'(s_lat), 32'(TMO));
        // R10: internal read waits past the limit
        set_addr({1'b1, 7'h0, CHIP, 5'd4, 3'd0, 6'd0, 2'b00});
        xfer(0, D_PRT, 4'hF, 0, 0, 2 * TMO, 32'h5A5A_A5A5);
        chk(s_rd == 32'h5A5A_A5A5, "R10 internal no timeout", s_rd, 32'h5A5A_A5A5);

        // Random accesses (R4 to R9, R12)
        for (int i = 0; i < 150; i++) begin
            logic [7:0] b;
            logic [4:0] d;
            int sel;
            sel = $urandom_range(0, 3);
            b = (sel == 0) ? 8'h00 : (sel == 1) ? CHIP : (sel == 2) ? SEC : 8'($urandom);
            d = ($urandom_range(0, 3) == 0) ? 5'd16 : 5'($urandom);
            cfg_case(b, d, 3'($urandom), 6'($urandom), 1'($urandom),
                     2'($urandom), 4'($urandom), $urandom, $urandom);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule